// File: doc/BRIEF.md
# Reservation Station Pool with Register Result Tracking

This block holds a small pool of reservation stations for a dynamically scheduled floating-point pipeline, together with the register file and a per-register producer table. When an instruction is issued, the block looks up both source registers. A source whose register has no pending producer is copied in as a value. A source whose register is waiting on a station is copied in as that station's tag. The destination register is then marked as owned by the station just allocated.

Functional units are outside the block. Each unit watches the ready flags and reads a station's operands through the peek port. When its result is done, the unit raises a finish request carrying the data. A fixed-priority arbiter lets one station broadcast on the common result bus per cycle. Every register and every station that is waiting on the broadcasting tag captures the value on that broadcast.

Tags run from 1 to the number of stations, and tag 0 means "value present". Load instructions keep their immediate offset in the station. The peek port exposes base plus offset as the effective address. A load is only offered for execution once every load issued before it has finished.

Top module: `rsv_pool`

## Requirements
- R1: After reset, no station is busy, `iss_ready` is 1 with `iss_tag` equal to 1, no station is ready, `cdb_valid` is 0, and register k reads value k with a producer tag of 0.
- R2: An issue takes the lowest-numbered free station, whose tag is its index plus 1. While all stations are busy, `iss_ready` is 0 and an `iss_valid` pulse changes no station and no register status.
- R3: A source register whose producer tag is 0 is issued as tag 0, with the register's current value copied into the station.
- R4: A source register whose producer tag is nonzero is issued with that tag copied into the station.
- R5: The destination register's producer tag becomes the allocated station's tag. Sources are looked up before this update, so an instruction whose source equals its destination waits on the previous producer.
- R6: A station is ready exactly when it is busy, both its operand tags are 0, and, for a load, no older load is still busy.
- R7: On a broadcast of tag t with value v, every register whose producer tag is t takes v and its tag becomes 0. A register re-owned by a later station keeps both its value and its tag.
- R8: On the same broadcast, every station waiting on t in either operand captures v into that operand and clears the operand's tag. Station t becomes free.
- R9: When an issue and a broadcast happen in the same cycle, a source waiting on the broadcasting tag is issued ready, holding the broadcast value.
- R10: Among finish requests from ready stations, the lowest-numbered station is granted the bus, with `fin_ack` one-hot. A finish request from a station that is not ready is ignored.
- R11: A load (`iss_load` = 1) uses only its first source. Its second operand is issued with tag 0 and value 0. `peek_addr` reads first operand plus the stored immediate.
- R12: A station freed by a broadcast is not offered for issue in the same cycle. `iss_tag` points at the next free station until the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OP_W | Operation code stored in the station |
| iss_dst | input | RIDX_W | Destination register index |
| iss_src1 | input | RIDX_W | First source register index |
| iss_src2 | input | RIDX_W | Second source register index (unused for loads) |
| iss_imm | input | DW | Immediate stored in the address field |
| iss_load | input | 1 | Instruction is a load |
| iss_ready | output | 1 | A station is free for issue this cycle |
| iss_tag | output | TAG_W | Tag an issue in this cycle would receive |
| st_busy | output | N_ST | Busy flag per station |
| st_ready | output | N_ST | Operands complete and allowed to execute, per station |
| fin_req | input | N_ST | Finish request per station |
| fin_data | input | N_ST*DW | Result value per station, station i at bits i*DW |
| fin_ack | output | N_ST | Bus grant, one-hot or zero |
| cdb_valid | output | 1 | A result is broadcast this cycle |
| cdb_tag | output | TAG_W | Tag of the broadcasting station |
| cdb_value | output | DW | Broadcast result value |
| peek_tag | input | TAG_W | Station selected for reading |
| peek_op | output | OP_W | Operation of the selected station |
| peek_qj | output | TAG_W | First operand tag |
| peek_qk | output | TAG_W | Second operand tag |
| peek_vj | output | DW | First operand value |
| peek_vk | output | DW | Second operand value |
| peek_addr | output | DW | First operand plus stored immediate |
| look_reg | input | RIDX_W | Register selected for reading |
| look_val | output | DW | Register value |
| look_qi | output | TAG_W | Register producer tag |

## Verification
The arbiter output (`fin_ack` and the `cdb_*` signals), `iss_ready` and `iss_tag` are combinational, so they are due in the same cycle as the request. The bench compares them one time unit after driving inputs, before the next rising edge. Station contents, ready flags and register status change at the rising edge that consumes an issue or a broadcast. The bench therefore steps one edge and then reads them through the peek and look ports. It drives inputs two units after each edge, so sampling and driving never coincide with an edge.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

  localparam int DEF_STATIONS = 4;
  localparam int DEF_DATA_W   = 32;
  localparam int DEF_REGS     = 8;
  localparam int DEF_OP_W     = 4;

  // tag 0 is reserved for "value present", so n stations need n+1 codes
  function automatic int tag_bits(input int n);
    return $clog2(n + 1);
  endfunction

  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rsv_pick.sv
module rsv_pick #(
  parameter int N     = 4,
  parameter int IDX_W = rsv_pkg::idx_bits(N)
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    any   = 1'b0;
    grant = '0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any   = 1'b1;
        grant = '0;
        grant[i] = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/rsv_regstat.sv
module rsv_regstat #(
  parameter int NREG   = 8,
  parameter int DW     = 32,
  parameter int TAG_W  = 3,
  parameter int RIDX_W = rsv_pkg::idx_bits(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RIDX_W-1:0] src1_idx,
  input  logic [RIDX_W-1:0] src2_idx,
  output logic [DW-1:0]     src1_val,
  output logic [TAG_W-1:0]  src1_qi,
  output logic [DW-1:0]     src2_val,
  output logic [TAG_W-1:0]  src2_qi,
  input  logic              set_we,
  input  logic [RIDX_W-1:0] set_idx,
  input  logic [TAG_W-1:0]  set_tag,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DW-1:0]     cdb_value,
  input  logic [RIDX_W-1:0] obs_idx,
  output logic [DW-1:0]     obs_val,
  output logic [TAG_W-1:0]  obs_qi
);

  logic [DW-1:0]    val_q [NREG];
  logic [TAG_W-1:0] qi_q  [NREG];
  logic [DW-1:0]    val_d [NREG];
  logic [TAG_W-1:0] qi_d  [NREG];

  always_comb begin
    for (int k = 0; k < NREG; k++) begin
      val_d[k] = val_q[k];
      qi_d[k]  = qi_q[k];
      if (cdb_valid && (qi_q[k] != '0) && (qi_q[k] == cdb_tag)) begin
        val_d[k] = cdb_value;
        qi_d[k]  = '0;
      end
      if (set_we && (set_idx == RIDX_W'(k))) begin
        qi_d[k] = set_tag;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NREG; k++) begin
        val_q[k] <= DW'(k);
        qi_q[k]  <= '0;
      end
    end else begin
      for (int k = 0; k < NREG; k++) begin
        val_q[k] <= val_d[k];
        qi_q[k]  <= qi_d[k];
      end
    end
  end

  assign src1_val = val_q[src1_idx];
  assign src1_qi  = qi_q[src1_idx];
  assign src2_val = val_q[src2_idx];
  assign src2_qi  = qi_q[src2_idx];
  assign obs_val  = val_q[obs_idx];
  assign obs_qi   = qi_q[obs_idx];

  for (genvar g = 0; g < NREG; g++) begin : g_chk
    // R7
    reg_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cdb_valid && qi_q[g] == cdb_tag && qi_q[g] != '0 &&
       !(set_we && set_idx == RIDX_W'(g)))
      |=> (qi_q[g] == '0 && val_q[g] == $past(cdb_value)));
    // R5
    reg_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_we && set_idx == RIDX_W'(g)) |=> (qi_q[g] == $past(set_tag)));
  end

endmodule

// File: rtl/rsv_station.sv
module rsv_station #(
  parameter int DW     = 32,
  parameter int TAG_W  = 3,
  parameter int OP_W   = 4,
  parameter int MY_TAG = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic [OP_W-1:0]  in_op,
  input  logic [TAG_W-1:0] in_qj,
  input  logic [DW-1:0]    in_vj,
  input  logic [TAG_W-1:0] in_qk,
  input  logic [DW-1:0]    in_vk,
  input  logic [DW-1:0]    in_a,
  input  logic             in_ld,
  input  logic [TAG_W-1:0] in_ahead,
  input  logic             cdb_valid,
  input  logic [TAG_W-1:0] cdb_tag,
  input  logic [DW-1:0]    cdb_value,
  input  logic             cdb_from_ld,
  output logic             busy,
  output logic             ready,
  output logic             is_ld,
  output logic [OP_W-1:0]  op,
  output logic [TAG_W-1:0] qj,
  output logic [TAG_W-1:0] qk,
  output logic [DW-1:0]    vj,
  output logic [DW-1:0]    vk,
  output logic [DW-1:0]    a
);

  localparam logic [TAG_W-1:0] SELF = TAG_W'(MY_TAG);

  logic             busy_q, busy_d;
  logic             ld_q, ld_d;
  logic [OP_W-1:0]  op_q, op_d;
  logic [TAG_W-1:0] qj_q, qj_d, qk_q, qk_d, ahead_q, ahead_d;
  logic [DW-1:0]    vj_q, vj_d, vk_q, vk_d, a_q, a_d;
  logic             hit_j, hit_k, hit_self, older_gone;

  assign hit_j      = cdb_valid && (qj_q != '0) && (qj_q == cdb_tag);
  assign hit_k      = cdb_valid && (qk_q != '0) && (qk_q == cdb_tag);
  assign hit_self   = cdb_valid && (cdb_tag == SELF);
  assign older_gone = cdb_valid && cdb_from_ld && !hit_self && (ahead_q != '0);

  always_comb begin
    busy_d  = busy_q;
    ld_d    = ld_q;
    op_d    = op_q;
    qj_d    = qj_q;
    qk_d    = qk_q;
    vj_d    = vj_q;
    vk_d    = vk_q;
    a_d     = a_q;
    ahead_d = ahead_q;
    if (alloc) begin
      busy_d  = 1'b1;
      ld_d    = in_ld;
      op_d    = in_op;
      qj_d    = in_qj;
      qk_d    = in_qk;
      vj_d    = in_vj;
      vk_d    = in_vk;
      a_d     = in_a;
      ahead_d = in_ld ? in_ahead : '0;
    end else if (busy_q) begin
      if (hit_j) begin
        qj_d = '0;
        vj_d = cdb_value;
      end
      if (hit_k) begin
        qk_d = '0;
        vk_d = cdb_value;
      end
      if (ld_q && older_gone) begin
        ahead_d = ahead_q - TAG_W'(1);
      end
      if (hit_self) begin
        busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      ld_q    <= 1'b0;
      op_q    <= '0;
      qj_q    <= '0;
      qk_q    <= '0;
      vj_q    <= '0;
      vk_q    <= '0;
      a_q     <= '0;
      ahead_q <= '0;
    end else begin
      busy_q  <= busy_d;
      ld_q    <= ld_d;
      op_q    <= op_d;
      qj_q    <= qj_d;
      qk_q    <= qk_d;
      vj_q    <= vj_d;
      vk_q    <= vk_d;
      a_q     <= a_d;
      ahead_q <= ahead_d;
    end
  end

  assign busy  = busy_q;
  assign ready = busy_q && (qj_q == '0) && (qk_q == '0) && (!ld_q || (ahead_q == '0));
  assign is_ld = ld_q;
  assign op    = op_q;
  assign qj    = qj_q;
  assign qk    = qk_q;
  assign vj    = vj_q;
  assign vk    = vk_q;
  assign a     = a_q;

  // R8
  wake_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !alloc && hit_j) |=> (qj_q == '0 && vj_q == $past(cdb_value)));
  // R8
  wake_k_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !alloc && hit_k) |=> (qk_q == '0 && vk_q == $past(cdb_value)));
  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && hit_self) |=> !busy_q);
  // R12
  no_self_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (qj_q != SELF && qk_q != SELF));
  // R11
  load_src2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && ld_q) |-> (qk_q == '0));

endmodule

// File: rtl/rsv_pool.sv
module rsv_pool #(
  parameter int N_ST   = rsv_pkg::DEF_STATIONS,
  parameter int DW     = rsv_pkg::DEF_DATA_W,
  parameter int NREG   = rsv_pkg::DEF_REGS,
  parameter int OP_W   = rsv_pkg::DEF_OP_W,
  parameter int TAG_W  = rsv_pkg::tag_bits(N_ST),
  parameter int RIDX_W = rsv_pkg::idx_bits(NREG)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 iss_valid,
  input  logic [OP_W-1:0]      iss_op,
  input  logic [RIDX_W-1:0]    iss_dst,
  input  logic [RIDX_W-1:0]    iss_src1,
  input  logic [RIDX_W-1:0]    iss_src2,
  input  logic [DW-1:0]        iss_imm,
  input  logic                 iss_load,
  output logic                 iss_ready,
  output logic [TAG_W-1:0]     iss_tag,
  output logic [N_ST-1:0]      st_busy,
  output logic [N_ST-1:0]      st_ready,
  input  logic [N_ST-1:0]      fin_req,
  input  logic [N_ST*DW-1:0]   fin_data,
  output logic [N_ST-1:0]      fin_ack,
  output logic                 cdb_valid,
  output logic [TAG_W-1:0]     cdb_tag,
  output logic [DW-1:0]        cdb_value,
  input  logic [TAG_W-1:0]     peek_tag,
  output logic [OP_W-1:0]      peek_op,
  output logic [TAG_W-1:0]     peek_qj,
  output logic [TAG_W-1:0]     peek_qk,
  output logic [DW-1:0]        peek_vj,
  output logic [DW-1:0]        peek_vk,
  output logic [DW-1:0]        peek_addr,
  input  logic [RIDX_W-1:0]    look_reg,
  output logic [DW-1:0]        look_val,
  output logic [TAG_W-1:0]     look_qi
);

  localparam int IDX_W = rsv_pkg::idx_bits(N_ST);

  logic [N_ST-1:0]  busy, ready, is_ld, alloc_oh, fin_oh;
  logic [OP_W-1:0]  s_op [N_ST];
  logic [TAG_W-1:0] s_qj [N_ST];
  logic [TAG_W-1:0] s_qk [N_ST];
  logic [DW-1:0]    s_vj [N_ST];
  logic [DW-1:0]    s_vk [N_ST];
  logic [DW-1:0]    s_a  [N_ST];

  logic             alloc_any, fin_any, do_iss, cdb_from_ld;
  logic [IDX_W-1:0] alloc_idx, fin_idx;

  logic [DW-1:0]    r1_val, r2_val;
  logic [TAG_W-1:0] r1_qi, r2_qi;
  logic [TAG_W-1:0] res_q1, res_q2, loads_ahead;
  logic [DW-1:0]    res_v1, res_v2;

  // free-station search, lowest index first
  rsv_pick #(.N(N_ST), .IDX_W(IDX_W)) u_alloc (
    .req   (~busy),
    .any   (alloc_any),
    .grant (alloc_oh),
    .idx   (alloc_idx)
  );

  // result bus arbiter: only stations allowed to execute may finish
  rsv_pick #(.N(N_ST), .IDX_W(IDX_W)) u_cdb_arb (
    .req   (fin_req & ready),
    .any   (fin_any),
    .grant (fin_oh),
    .idx   (fin_idx)
  );

  assign iss_ready   = alloc_any;
  assign iss_tag     = alloc_any ? (TAG_W'(alloc_idx) + TAG_W'(1)) : '0;
  assign do_iss      = iss_valid && alloc_any;
  assign fin_ack     = fin_oh;
  assign cdb_valid   = fin_any;
  assign cdb_tag     = fin_any ? (TAG_W'(fin_idx) + TAG_W'(1)) : '0;
  assign cdb_value   = fin_data[fin_idx*DW +: DW];
  assign cdb_from_ld = fin_any && is_ld[fin_idx];

  rsv_regstat #(.NREG(NREG), .DW(DW), .TAG_W(TAG_W), .RIDX_W(RIDX_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .src1_idx  (iss_src1),
    .src2_idx  (iss_src2),
    .src1_val  (r1_val),
    .src1_qi   (r1_qi),
    .src2_val  (r2_val),
    .src2_qi   (r2_qi),
    .set_we    (do_iss),
    .set_idx   (iss_dst),
    .set_tag   (iss_tag),
    .cdb_valid (cdb_valid),
    .cdb_tag   (cdb_tag),
    .cdb_value (cdb_value),
    .obs_idx   (look_reg),
    .obs_val   (look_val),
    .obs_qi    (look_qi)
  );

  // source resolution, including a broadcast landing in the issue cycle
  always_comb begin
    res_q1 = r1_qi;
    res_v1 = '0;
    if (r1_qi == '0) begin
      res_v1 = r1_val;
    end else if (cdb_valid && (cdb_tag == r1_qi)) begin
      res_q1 = '0;
      res_v1 = cdb_value;
    end
    res_q2 = r2_qi;
    res_v2 = '0;
    if (iss_load) begin
      res_q2 = '0;
    end else if (r2_qi == '0) begin
      res_v2 = r2_val;
    end else if (cdb_valid && (cdb_tag == r2_qi)) begin
      res_q2 = '0;
      res_v2 = cdb_value;
    end
  end

  // loads still in flight after this cycle's broadcast
  always_comb begin
    loads_ahead = '0;
    for (int i = 0; i < N_ST; i++) begin
      if (busy[i] && is_ld[i] && !fin_oh[i]) begin
        loads_ahead = loads_ahead + TAG_W'(1);
      end
    end
  end

  for (genvar g = 0; g < N_ST; g++) begin : g_st
    rsv_station #(.DW(DW), .TAG_W(TAG_W), .OP_W(OP_W), .MY_TAG(g + 1)) u_st (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc       (do_iss && alloc_oh[g]),
      .in_op       (iss_op),
      .in_qj       (res_q1),
      .in_vj       (res_v1),
      .in_qk       (res_q2),
      .in_vk       (res_v2),
      .in_a        (iss_imm),
      .in_ld       (iss_load),
      .in_ahead    (loads_ahead),
      .cdb_valid   (cdb_valid),
      .cdb_tag     (cdb_tag),
      .cdb_value   (cdb_value),
      .cdb_from_ld (cdb_from_ld),
      .busy        (busy[g]),
      .ready       (ready[g]),
      .is_ld       (is_ld[g]),
      .op          (s_op[g]),
      .qj          (s_qj[g]),
      .qk          (s_qk[g]),
      .vj          (s_vj[g]),
      .vk          (s_vk[g]),
      .a           (s_a[g])
    );
  end

  assign st_busy  = busy;
  assign st_ready = ready;

  always_comb begin
    peek_op   = '0;
    peek_qj   = '0;
    peek_qk   = '0;
    peek_vj   = '0;
    peek_vk   = '0;
    peek_addr = '0;
    for (int i = 0; i < N_ST; i++) begin
      if (peek_tag == TAG_W'(i + 1)) begin
        peek_op   = s_op[i];
        peek_qj   = s_qj[i];
        peek_qk   = s_qk[i];
        peek_vj   = s_vj[i];
        peek_vk   = s_vk[i];
        peek_addr = s_vj[i] + s_a[i];
      end
    end
  end

  // R10
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fin_ack) && ((fin_ack & ~(fin_req & st_ready)) == '0));
  // R2
  alloc_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_iss |=> $countones(st_busy) >= 1);
  // R12
  no_reuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_iss && cdb_valid) |-> (iss_tag != cdb_tag));
  // R6
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_ready & ~st_busy) == '0);

endmodule

// File: tb/sim_rsv_pool.sv
`timescale 1ns/1ps
module sim_rsv_pool;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         iss_valid;
  logic [3:0]   iss_op;
  logic [2:0]   iss_dst, iss_src1, iss_src2;
  logic [31:0]  iss_imm;
  logic         iss_load;
  logic         iss_ready;
  logic [2:0]   iss_tag;
  logic [3:0]   st_busy, st_ready, fin_req, fin_ack;
  logic [127:0] fin_data;
  logic         cdb_valid;
  logic [2:0]   cdb_tag;
  logic [31:0]  cdb_value;
  logic [2:0]   peek_tag, peek_qj, peek_qk;
  logic [3:0]   peek_op;
  logic [31:0]  peek_vj, peek_vk, peek_addr;
  logic [2:0]   look_reg, look_qi;
  logic [31:0]  look_val;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] expv [8];

  always #5 clk = ~clk;

  rsv_pool u0 (.*);

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exv);
    n_chk++;
    if (act !== exv) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exv);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic issue(input logic [3:0] op, input int dst, input int s1, input int s2,
                       input logic [31:0] imm, input logic ld);
    iss_valid = 1'b1; iss_op = op; iss_dst = 3'(dst); iss_src1 = 3'(s1);
    iss_src2 = 3'(s2); iss_imm = imm; iss_load = ld;
    step();
    iss_valid = 1'b0; iss_load = 1'b0;
  endtask

  task automatic look(input int r);
    look_reg = 3'(r); #1;
  endtask

  task automatic peek(input int t);
    peek_tag = 3'(t); #1;
  endtask

  task automatic set_fin(input int i, input logic [31:0] v);
    fin_req[i] = 1'b1;
    fin_data[i*32 +: 32] = v;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; iss_valid = 1'b0; iss_op = '0; iss_dst = '0; iss_src1 = '0;
    iss_src2 = '0; iss_imm = '0; iss_load = 1'b0; fin_req = '0; fin_data = '0;
    peek_tag = '0; look_reg = '0;
    for (int k = 0; k < 8; k++) expv[k] = 32'(k);
    #23 rst_n = 1'b1;
    step();

    // R1 reset state
    #1;
    chk("R1 iss_ready", 32'(iss_ready), 1);
    chk("R1 iss_tag", 32'(iss_tag), 1);
    chk("R1 busy", 32'(st_busy), 0);
    chk("R1 ready", 32'(st_ready), 0);
    chk("R1 cdb_valid", 32'(cdb_valid), 0);
    for (int k = 0; k < 8; k++) begin
      look(k);
      chk("R1 reg value", look_val, 32'(k));
      chk("R1 reg tag", 32'(look_qi), 0);
    end

    // sweep of source/destination combinations with no pending producers
    for (int s = 0; s < 8; s++) begin
      int d, s2;
      d = (s + 5) % 8; s2 = (s + 2) % 8;
      issue(4'(s), d, s, s2, 32'(16 * s), 1'b0);
      peek(1);
      chk("R3 vj", peek_vj, expv[s]);
      chk("R3 vk", peek_vk, expv[s2]);
      chk("R3 qj", 32'(peek_qj), 0);
      chk("R3 qk", 32'(peek_qk), 0);
      chk("R3 op", 32'(peek_op), 32'(s));
      chk("R11 addr sum", peek_addr, expv[s] + 32'(16 * s));
      chk("R6 ready", 32'(st_ready), 1);
      look(d);
      chk("R5 dst tag", 32'(look_qi), 1);
      set_fin(0, 32'(1000 + s)); #1;
      chk("R10 cdb valid", 32'(cdb_valid), 1);
      chk("R10 cdb tag", 32'(cdb_tag), 1);
      chk("R10 cdb value", cdb_value, 32'(1000 + s));
      step();
      fin_req = '0;
      expv[d] = 32'(1000 + s);
      look(d);
      chk("R7 reg value", look_val, expv[d]);
      chk("R7 reg tag", 32'(look_qi), 0);
      chk("R8 freed", 32'(st_busy), 0);
    end

    // dependency chain
    issue(4'd1, 2, 0, 1, 0, 1'b0);
    issue(4'd2, 4, 2, 3, 0, 1'b0);
    issue(4'd3, 6, 4, 2, 0, 1'b0);
    peek(2);
    chk("R4 chain qj", 32'(peek_qj), 1);
    chk("R3 chain vk", peek_vk, expv[3]);
    peek(3);
    chk("R4 chain qj2", 32'(peek_qj), 2);
    chk("R4 chain qk2", 32'(peek_qk), 1);
    chk("R6 chain ready", 32'(st_ready), 32'b0001);
    set_fin(0, 32'd77); step(); fin_req = '0;
    peek(2);
    chk("R8 wake vj", peek_vj, 77);
    chk("R8 wake qj", 32'(peek_qj), 0);
    peek(3);
    chk("R8 wake vk", peek_vk, 77);
    chk("R8 still waiting qj", 32'(peek_qj), 2);
    chk("R6 after wake", 32'(st_ready), 32'b0010);
    look(2);
    chk("R7 chain reg2", look_val, 77);
    set_fin(1, 32'd88); step(); fin_req = '0;
    peek(3);
    chk("R8 second wake", peek_vj, 88);
    chk("R6 last ready", 32'(st_ready), 32'b0100);
    set_fin(2, 32'd99); step(); fin_req = '0;
    look(6);
    chk("R7 chain reg6", look_val, 99);
    expv[2] = 77; expv[4] = 88; expv[6] = 99;

    // full pool and arbitration order
    for (int i = 0; i < 4; i++) issue(4'(i), i, 5, 6, 0, 1'b0);
    #1;
    chk("R2 full ready", 32'(iss_ready), 0);
    chk("R2 all busy", 32'(st_busy), 32'hF);
    issue(4'd9, 7, 5, 6, 0, 1'b0);
    look(7);
    chk("R2 ignored issue", 32'(look_qi), 0);
    chk("R2 still busy", 32'(st_busy), 32'hF);
    for (int i = 0; i < 4; i++) set_fin(i, 32'(500 + i));
    for (int i = 0; i < 4; i++) begin
      #1;
      chk("R10 priority tag", 32'(cdb_tag), 32'(i + 1));
      chk("R10 ack", 32'(fin_ack), 32'(1 << i));
      step();
    end
    #1;
    chk("R10 bus idle", 32'(cdb_valid), 0);
    fin_req = '0;
    for (int i = 0; i < 4; i++) expv[i] = 32'(500 + i);

    // issue and broadcast in the same cycle
    issue(4'd1, 5, 0, 1, 0, 1'b0);
    set_fin(0, 32'd55);
    iss_valid = 1'b1; iss_op = 4'd2; iss_dst = 3'd6; iss_src1 = 3'd5; iss_src2 = 3'd5;
    #1;
    chk("R12 no same-cycle reuse", 32'(iss_tag), 2);
    step();
    iss_valid = 1'b0; fin_req = '0;
    peek(2);
    chk("R9 vj", peek_vj, 55);
    chk("R9 qj", 32'(peek_qj), 0);
    chk("R9 vk", peek_vk, 55);
    chk("R9 qk", 32'(peek_qk), 0);
    look(6);
    chk("R5 same-cycle dst", 32'(look_qi), 2);
    set_fin(1, 32'd66); step(); fin_req = '0;
    expv[5] = 55; expv[6] = 66;

    // source equals destination
    issue(4'd1, 3, 0, 1, 0, 1'b0);
    issue(4'd2, 3, 3, 1, 0, 1'b0);
    peek(2);
    chk("R5 old producer", 32'(peek_qj), 1);
    look(3);
    chk("R5 new owner", 32'(look_qi), 2);
    set_fin(0, 32'd11); step(); fin_req = '0;
    look(3);
    chk("R7 reowned tag", 32'(look_qi), 2);
    chk("R7 reowned value", look_val, expv[3]);
    peek(2);
    chk("R8 src=dst wake", peek_vj, 11);
    set_fin(1, 32'd22); step(); fin_req = '0;
    look(3);
    chk("R7 final value", look_val, 22);
    expv[3] = 22;

    // load ordering
    issue(4'd7, 1, 3, 6, 32'd40, 1'b1);
    issue(4'd7, 2, 4, 6, 32'd8, 1'b1);
    issue(4'd5, 0, 5, 6, 0, 1'b0);
    peek(1);
    chk("R11 addr", peek_addr, expv[3] + 40);
    chk("R11 vk zero", peek_vk, 0);
    chk("R11 qk zero", 32'(peek_qk), 0);
    chk("R6 load order", 32'(st_ready), 32'b0101);
    set_fin(1, 32'd123); #1;
    chk("R10 not ready ignored", 32'(cdb_valid), 0);
    step(); fin_req = '0;
    chk("R10 ignored busy", 32'(st_busy), 32'b0111);
    set_fin(0, 32'd31); step(); fin_req = '0;
    chk("R6 next load ready", 32'(st_ready), 32'b0110);
    set_fin(1, 32'd32); set_fin(2, 32'd33); #1;
    chk("R10 load first", 32'(cdb_tag), 2);
    step(); #1;
    chk("R10 then alu", 32'(cdb_tag), 3);
    step(); fin_req = '0;
    look(2);
    chk("R7 load result", look_val, 32);
    chk("R8 drained", 32'(st_busy), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule